// File: doc/BRIEF.md
# Double-Buffered Serial Converter Input Logic

This block is the digital front end of a serial-input voltage converter. A host drives three slow pins: serial data, serial clock and an active-low load strobe. An active-low clear pin can also be used. The block samples every pin in a fast system-clock domain through two-flop synchronizers and detects serial-clock edges from the synchronized values. Each detected rising serial-clock edge shifts one bit into a shift register, most significant bit first. A separate holding register drives the parallel code output, which stands in for the analog output.

The load strobe is level-sensitive. While it is high, shifting is enabled and the holding register keeps its value, so a new word can be preloaded without disturbing the output. While it is low, serial-clock edges are ignored and the holding register is transparent to the shift register. Clear overrides load. It blanks the output combinationally as soon as it goes low, and it zeroes the holding register. When clear is released, the holding register takes the shift register if load is low and stays at zero if load is high. Frames longer than the resolution keep only the last bits clocked in, so a host that sends whole bytes can pad the front of the frame with don't-care bits.

Top module: `sdac_front`

## Requirements
- R1: After system reset both the shift register and the holding register are zero: `code_o` is 0, and it stays 0 when load is first driven low without any serial clocks.
- R2: Each synchronized rising edge of `sclk_i` while `load_n_i` is high shifts `sdata_i` into the least significant end of the shift register. After DATA_W clocks and a low load, `code_o` equals the word sent most significant bit first.
- R3: Rising edges of `sclk_i` while `load_n_i` is low leave the shift register unchanged, and they leave `code_o` unchanged.
- R4: While `load_n_i` is low and `clear_n_i` is high, the holding register follows the shift register. A high-to-low transition of load therefore transfers the new word, and `code_o` shows it within 3 system clocks.
- R5: While `load_n_i` is high, `code_o` keeps its previous value while a new word is being shifted in.
- R6: While `clear_n_i` is low, `code_o` is zero whatever the level of load. The output is blanked in the same cycle that clear falls, and the holding register is zeroed.
- R7: If clear rises while load is low, `code_o` takes the shift-register contents within 3 system clocks.
- R8: If clear rises while load is high, `code_o` stays zero until load next goes low, and it then shows the shift-register contents.
- R9: If more than DATA_W bits are shifted before load goes low, only the last DATA_W bits are kept. With the default DATA_W of 12, a 16-bit frame 0xBEEF yields code 0xEEF. DATA_W may be 10 or 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous system reset |
| sclk_i | input | 1 | Serial clock pin; data is taken on its rising edge |
| sdata_i | input | 1 | Serial data pin, most significant bit first |
| load_n_i | input | 1 | Active-low, level-sensitive load strobe; also gates the serial clock |
| clear_n_i | input | 1 | Active-low clear; zeroes the output and the holding register |
| code_o | output | DATA_W | Parallel code output of the holding register |

## Verification
A pin change is seen by the logic after two system-clock edges, in the synchronizer. The shift register or holding register then updates on the third edge. The code output is therefore due three clocks after a serial-clock, load or clear-release change. The one exception is a falling clear, which blanks the output combinationally in the same cycle. The bench changes pins on falling clock edges and samples four falling edges later, so every registered result has settled. It checks the clear blanking one time unit after driving the pin, before any rising edge occurs.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int SYNC_DEPTH = 2;
  localparam int PIN_COUNT  = 4;

  typedef struct packed {
    logic sclk;
    logic sdata;
    logic load_n;
    logic clear_n;
  } pin_bundle_t;

  localparam pin_bundle_t PIN_IDLE = '{sclk: 1'b0, sdata: 1'b0, load_n: 1'b1, clear_n: 1'b1};
endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
  parameter int            WIDTH   = 4,
  parameter int            STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stage_q[s] <= raw_i;
      end else begin
        stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdata_s,
  input  logic              load_n_s,
  output logic [DATA_W-1:0] word_o
);
  logic              sclk_q;
  logic              shift_en;
  logic [DATA_W-1:0] sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign shift_en = sclk_s & ~sclk_q & load_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sreg_q <= '0;
    else if (shift_en) sreg_q <= {sreg_q[DATA_W-2:0], sdata_s};
  end

  assign word_o = sreg_q;

  // R3
  ignore_clk_when_loading_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_s |=> $stable(sreg_q));

  // R2
  shift_takes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_s && !sclk_q && load_n_s) |=> (sreg_q[0] == $past(sdata_s)));
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_n_s,
  input  logic              load_n_s,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] hold_o
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_q <= '0;
    else if (!clear_n_s) hold_q <= '0;
    else if (!load_n_s)  hold_q <= word_i;
  end

  assign hold_o = hold_q;

  // R6
  clear_zeroes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n_s |=> (hold_q == '0));

  // R4
  transparent_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n_s && !load_n_s) |=> (hold_q == $past(word_i)));

  // R5
  hold_while_shifting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n_s && load_n_s) |=> $stable(hold_q));
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              load_n_i,
  input  logic              clear_n_i,
  output logic [DATA_W-1:0] code_o
);
  import sdac_pkg::*;

  pin_bundle_t       pins_raw;
  pin_bundle_t       pins_s;
  logic [PIN_COUNT-1:0] pins_s_vec;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] hold;

  assign pins_raw = '{sclk: sclk_i, sdata: sdata_i, load_n: load_n_i, clear_n: clear_n_i};

  sdac_pin_sync #(
    .WIDTH  (PIN_COUNT),
    .STAGES (SYNC_DEPTH),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (pins_raw),
    .sync_o(pins_s_vec)
  );

  assign pins_s = pins_s_vec;

  sdac_shift #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (pins_s.sclk),
    .sdata_s (pins_s.sdata),
    .load_n_s(pins_s.load_n),
    .word_o  (word)
  );

  sdac_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_n_s(pins_s.clear_n),
    .load_n_s (pins_s.load_n),
    .word_i   (word),
    .hold_o   (hold)
  );

  assign code_o = clear_n_i ? hold : '0;

  // R7
  clear_release_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pins_s.clear_n) && pins_s.clear_n && !pins_s.load_n) |=> (hold == $past(word)));

  // R8
  clear_release_stays_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pins_s.clear_n) && pins_s.clear_n && pins_s.load_n) |=> (hold == '0));
endmodule

// File: tb/sim_sdac_front.sv
module sim_sdac_front;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0;
  logic          sdata = 1'b0;
  logic          load_n = 1'b1;
  logic          clear_n = 1'b1;
  logic [DW-1:0] code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sdac_front #(.DATA_W(DW)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_i   (sclk),
    .sdata_i  (sdata),
    .load_n_i (load_n),
    .clear_n_i(clear_n),
    .code_o   (code)
  );

  // {bit count, frame, expected code}
  localparam logic [32:0] VECS [0:6] = '{
    {5'd12, 16'h0A5C, 12'hA5C},
    {5'd12, 16'h0FFF, 12'hFFF},
    {5'd12, 16'h0000, 12'h000},
    {5'd16, 16'hBEEF, 12'hEEF},
    {5'd16, 16'h1801, 12'h801},
    {5'd13, 16'h1ABC, 12'hABC},
    {5'd12, 16'h0800, 12'h800}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: code_o actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdata = b;
    wait_n(4);
    sclk = 1'b1;
    wait_n(4);
    sclk = 1'b0;
    wait_n(4);
  endtask

  task automatic send_frame(input int nbits, input logic [15:0] frame);
    for (int i = nbits - 1; i >= 0; i--) send_bit(frame[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] prev;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    chk("R1 reset output", code, '0);
    load_n = 1'b0;
    wait_n(4);
    chk("R1 reset shift register", code, '0);
    load_n = 1'b1;
    wait_n(4);

    prev = '0;
    for (int v = 0; v < 7; v++) begin
      send_frame(int'(VECS[v][32:28]), VECS[v][27:12]);
      chk("R5 hold while shifting", code, prev);
      load_n = 1'b0;
      wait_n(4);
      chk("R2/R4/R9 transfer on load", code, VECS[v][11:0]);
      load_n = 1'b1;
      wait_n(4);
      chk("R5 kept after load high", code, VECS[v][11:0]);
      prev = VECS[v][11:0];
    end

    // R3: clocks during low load are ignored
    send_frame(12, 16'h0123);
    load_n = 1'b0;
    wait_n(4);
    chk("R4 load low", code, 12'h123);
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b0);
    chk("R3 clocks ignored at output", code, 12'h123);
    load_n = 1'b1;
    wait_n(4);
    load_n = 1'b0;
    wait_n(4);
    chk("R3 shift register untouched", code, 12'h123);
    load_n = 1'b1;
    wait_n(4);

    // R6: immediate blanking and register zeroing
    clear_n = 1'b0;
    #1;
    chk("R6 immediate blank", code, '0);
    wait_n(4);
    chk("R6 held at zero", code, '0);

    // R7: clear released with load low
    send_frame(12, 16'h03C3);
    load_n = 1'b0;
    wait_n(4);
    chk("R6 zero despite load low", code, '0);
    clear_n = 1'b1;
    wait_n(4);
    chk("R7 release copies shift", code, 12'h3C3);

    // R8: clear released with load high
    load_n = 1'b1;
    wait_n(4);
    clear_n = 1'b0;
    wait_n(4);
    clear_n = 1'b1;
    wait_n(6);
    chk("R8 stays zero", code, '0);
    load_n = 1'b0;
    wait_n(4);
    chk("R8 next load copies", code, 12'h3C3);
    load_n = 1'b1;
    wait_n(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule